// File: doc/BRIEF.md
# Multiplexed SAR ADC Host Sequencer

This block drives an eight-input multiplexed serial SAR converter from the host side. A user hands it one request at a time. Each request names an input channel, a single-ended or differential choice, the polarity of a differential pair, whether the top input acts as a shared negative return, unipolar or bipolar coding, and a sleep flag. The block packs these into the converter's 7-bit configuration word. It shifts that word out while it shifts in the previous result. It then waits out the acquisition window and raises the chip-select/convert line to start a conversion of fixed length.

The converter's serial exchange is pipelined. The word sent during a serial phase configures the conversion that follows it, and the result read during that phase belongs to the conversion before it. The block therefore returns each result tagged with the configuration word that produced it. The first result after reset has no conversion behind it and is marked with a flag. Requests that the converter cannot honour while the top input is the shared return are refused with an error pulse, and no bus activity follows them.

Top module: `adcmux_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1 and `adc_cs`, `adc_sck`, `res_valid` and `req_err` are 0.
- R2: For a single-ended request (`req_single`=1) the word carries SD=1, OS=`req_chan[0]`, S1=`req_chan[2]`, S0=`req_chan[1]`.
- R3: For a differential request (`req_single`=0) the word carries SD=0, S1=`req_chan[2]`, S0=`req_chan[1]`, OS=`req_swap`; `req_chan[0]` has no effect on the word.
- R4: The word is sent MSB first in the order SD, OS, S1, S0, COM, UNI, SLP. COM, UNI and SLP come from `req_com`, `req_unipolar` and `req_sleep`.
- R5: With `req_com`=1, a single-ended request for channel 7 or a differential request for pair 3 (`req_chan[2:1]`=3) is refused. `req_err` is 1 for the one cycle after acceptance, and no serial clock or conversion follows.
- R6: An accepted legal request gives exactly RES_BITS serial clock pulses with `adc_cs` low. The 7 word bits are driven on `adc_sdi` and then zeros. `adc_sdo` is sampled on each rising `adc_sck`, MSB first.
- R7: After the serial phase, `res_valid` pulses for one cycle with the received bits on `res_data`. `res_tag` carries the word of the previous legal request, and `res_first`=1 (tag 0) only on the first result after reset.
- R8: `adc_cs` rises exactly ACQ_CYCLES clocks after the last falling `adc_sck`, where ACQ_CYCLES = ceil(ACQ_NS × CLK_MHZ / 1000).
- R9: `adc_cs` stays high for exactly CONV_CYCLES clocks and cannot be retriggered. `adc_sck` stays low while it is high.
- R10: `req_ready` is 0 from acceptance of a legal request until `adc_cs` falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_chan | input | 3 | Channel number (pair in bits 2:1 for differential) |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_swap | input | 1 | Differential polarity: 1 puts odd input positive |
| req_com | input | 1 | Top input used as shared negative return |
| req_unipolar | input | 1 | Unipolar coding |
| req_sleep | input | 1 | Sleep after conversion |
| req_err | output | 1 | One-cycle pulse: request refused |
| res_valid | output | 1 | One-cycle pulse: result available |
| res_data | output | RES_BITS | Result word |
| res_tag | output | 7 | Configuration word of the conversion that produced the result |
| res_first | output | 1 | Result has no conversion behind it |
| adc_cs | output | 1 | Chip-select / convert start |
| adc_sck | output | 1 | Serial clock, idles low |
| adc_sdi | output | 1 | Configuration data to converter |
| adc_sdo | input | 1 | Result data from converter |

## Verification
On every cycle the assertions check the timing rules. The convert pulse has its exact length and is never restarted. Acquisition never falls short. No serial clock appears during a conversion. The ready line stays low while busy, results come as single-cycle pulses, and a refusal leaves the bus quiet. Only the bench's scenarios can show that the bits reaching a behavioural converter match the encoding rules for each channel, pair, polarity and mode combination. The same holds for the result/tag pairing across the one-deep pipeline, the first-result flag, the padding zeros after the word, and that the refused combinations leave the pipeline untouched.

// File: rtl/adcmux_pkg.sv
// Shared types for the multiplexed ADC host sequencer.
// Assumes: 7-bit configuration word sent MSB first, field order fixed by the converter.
package adcmux_pkg;

    localparam int CFG_BITS = 7;

    // Field order matches the shift order: sd is transmitted first.
    typedef struct packed {
        logic sd;    // 1 = single-ended
        logic os;    // odd select / pair polarity
        logic s1;    // address high
        logic s0;    // address low
        logic com;   // top input is shared return
        logic uni;   // unipolar coding
        logic slp;   // sleep after conversion
    } cfg_word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ACQ   = 2'd2,
        ST_CONV  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/adcmux_encoder.sv
// Builds the converter configuration word from a channel request and flags
// combinations that are illegal when the top input is the shared return.
// Assumes: purely combinational, inputs held stable by the caller.
module adcmux_encoder
    import adcmux_pkg::*;
(
    input  logic [2:0] chan,
    input  logic       single,
    input  logic       swap,
    input  logic       com,
    input  logic       uni,
    input  logic       slp,
    output cfg_word_t  word,
    output logic       illegal
);

    logic odd_sel;

    // Purpose: pick the odd-select bit from the channel LSB or the pair polarity.
    always_comb begin
        odd_sel = single ? chan[0] : swap;
    end

    // Purpose: assemble the configuration fields.
    always_comb begin
        word.sd  = single;
        word.os  = odd_sel;
        word.s1  = chan[2];
        word.s0  = chan[1];
        word.com = com;
        word.uni = uni;
        word.slp = slp;
    end

    // Purpose: refuse any use of input 7 as a measured input while it is the return.
    always_comb begin
        illegal = com && (chan[2:1] == 2'b11) && (single ? chan[0] : 1'b1);
    end

endmodule

// File: rtl/adcmux_shifter.sv
// Full-duplex serial engine. It sends the configuration word padded with
// zeros and collects RES_BITS result bits. The clock idles low, the input is
// sampled on rising edges, and the output advances on falling edges.
// Assumes: RES_BITS > CFG_BITS; start only when idle.
module adcmux_shifter
    import adcmux_pkg::*;
#(
    parameter int RES_BITS = 16,
    parameter int SCK_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  cfg_word_t           cfg,
    input  logic                sdo,
    output logic                sck,
    output logic                sdi,
    output logic                done,
    output logic [RES_BITS-1:0] rx_data
);

    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int CNT_W = $clog2(RES_BITS + 1);
    localparam int PAD_BITS = RES_BITS - CFG_BITS;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(RES_BITS - 1);

    logic [RES_BITS-1:0] tx_q;
    logic [RES_BITS-1:0] rx_q;
    logic [DIV_W-1:0]    div_q;
    logic [CNT_W-1:0]    bit_q;
    logic                sck_q;
    logic                busy_q;
    logic                tick;

    assign tick    = busy_q && (div_q == DIV_LAST);
    assign done    = tick && sck_q && (bit_q == BIT_LAST);
    assign sck     = sck_q;
    assign sdi     = busy_q && tx_q[RES_BITS-1];
    assign rx_data = rx_q;

    // Purpose: divide the clock, toggle the serial clock and move data both ways.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            div_q  <= '0;
            bit_q  <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
        end else if (start) begin
            tx_q   <= {cfg, {PAD_BITS{1'b0}}};
            div_q  <= '0;
            bit_q  <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                sck_q <= ~sck_q;
                if (!sck_q) begin
                    rx_q <= {rx_q[RES_BITS-2:0], sdo};
                end else begin
                    tx_q  <= {tx_q[RES_BITS-2:0], 1'b0};
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == BIT_LAST) begin
                        busy_q <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/adcmux_seq.sv
// Top-level sequencer. It accepts a request, runs the serial phase, times
// the acquisition window, holds the convert line high for a fixed time and
// hands back each result with the word of the conversion that produced it.
// Assumes: ACQ_CYCLES >= 1, CONV_CYCLES >= 1.
module adcmux_seq
    import adcmux_pkg::*;
#(
    parameter int RES_BITS    = 16,
    parameter int ACQ_CYCLES  = 201,
    parameter int CONV_CYCLES = 350
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                illegal,
    input  cfg_word_t           word,
    output logic                req_ready,
    output logic                start,
    input  logic                done,
    input  logic [RES_BITS-1:0] rx_data,
    output logic                cs,
    output logic                err,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output cfg_word_t           res_tag,
    output logic                res_first
);

    localparam int WAIT_MAX = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam logic [WAIT_W-1:0] ACQ_LAST  = WAIT_W'(ACQ_CYCLES - 1);
    localparam logic [WAIT_W-1:0] CONV_LAST = WAIT_W'(CONV_CYCLES - 1);

    seq_state_t          state_q;
    logic [WAIT_W-1:0]   wait_q;
    logic                cs_q;
    logic                err_q;
    logic                valid_q;
    logic [RES_BITS-1:0] data_q;
    cfg_word_t           tag_q;
    cfg_word_t           cur_q;
    cfg_word_t           prev_q;
    logic                first_q;
    logic                seen_q;
    logic                accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign start     = accept && !illegal;
    assign cs        = cs_q;
    assign err       = err_q;
    assign res_valid = valid_q;
    assign res_data  = data_q;
    assign res_tag   = tag_q;
    assign res_first = first_q;

    // Purpose: step through idle, serial, acquire and convert with one shared timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
            cs_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (done) begin
                        state_q <= ST_ACQ;
                        wait_q  <= '0;
                    end
                end
                ST_ACQ: begin
                    if (wait_q == ACQ_LAST) begin
                        state_q <= ST_CONV;
                        wait_q  <= '0;
                        cs_q    <= 1'b1;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (wait_q == CONV_LAST) begin
                        state_q <= ST_IDLE;
                        cs_q    <= 1'b0;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: pulse the refusal flag for an illegal accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= accept && illegal;
        end
    end

    // Purpose: keep the word pipeline and publish each result with its tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            tag_q   <= '0;
            cur_q   <= '0;
            prev_q  <= '0;
            first_q <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            valid_q <= done;
            if (start) begin
                cur_q <= word;
            end
            if (done) begin
                data_q  <= rx_data;
                tag_q   <= prev_q;
                prev_q  <= cur_q;
                first_q <= !seen_q;
                seen_q  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adcmux_ctrl.sv
// Host controller for an 8-input multiplexed serial SAR converter.
// Wires the word encoder, the serial engine and the phase sequencer.
// Assumes: synchronous active-low reset; RES_BITS is 12 or 16.
module adcmux_ctrl
    import adcmux_pkg::*;
#(
    parameter int RES_BITS    = 16,
    parameter int CLK_MHZ     = 100,
    parameter int ACQ_NS      = 2010,
    parameter int CONV_CYCLES = 350,
    parameter int SCK_HALF    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_chan,
    input  logic                req_single,
    input  logic                req_swap,
    input  logic                req_com,
    input  logic                req_unipolar,
    input  logic                req_sleep,
    output logic                req_err,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic [6:0]          res_tag,
    output logic                res_first,
    output logic                adc_cs,
    output logic                adc_sck,
    output logic                adc_sdi,
    input  logic                adc_sdo
);

    localparam int ACQ_CYCLES = (ACQ_NS * CLK_MHZ + 999) / 1000;

    cfg_word_t           enc_word;
    cfg_word_t           tag_w;
    logic                enc_illegal;
    logic                sh_start;
    logic                sh_done;
    logic [RES_BITS-1:0] sh_rx;

    assign res_tag = tag_w;

    adcmux_encoder u_enc (
        .chan    (req_chan),
        .single  (req_single),
        .swap    (req_swap),
        .com     (req_com),
        .uni     (req_unipolar),
        .slp     (req_sleep),
        .word    (enc_word),
        .illegal (enc_illegal)
    );

    adcmux_shifter #(
        .RES_BITS (RES_BITS),
        .SCK_HALF (SCK_HALF)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .cfg     (enc_word),
        .sdo     (adc_sdo),
        .sck     (adc_sck),
        .sdi     (adc_sdi),
        .done    (sh_done),
        .rx_data (sh_rx)
    );

    adcmux_seq #(
        .RES_BITS    (RES_BITS),
        .ACQ_CYCLES  (ACQ_CYCLES),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .illegal   (enc_illegal),
        .word      (enc_word),
        .req_ready (req_ready),
        .start     (sh_start),
        .done      (sh_done),
        .rx_data   (sh_rx),
        .cs        (adc_cs),
        .err       (req_err),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_tag   (tag_w),
        .res_first (res_first)
    );

endmodule

// File: rtl/adcmux_ctrl_chk.sv
// Timing checker for the ADC host sequencer, bound to the top module.
// Assumes: counters run from reset; long windows are measured with counters.
module adcmux_ctrl_chk #(
    parameter int ACQ_CYCLES  = 201,
    parameter int CONV_CYCLES = 350
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic req_err,
    input logic res_valid,
    input logic adc_cs,
    input logic adc_sck
);

    int unsigned hi_cnt;
    int unsigned gap_cnt;
    logic        sck_d;

    // Purpose: count cycles the convert line has been high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 0;
        end else if (adc_cs) begin
            hi_cnt <= hi_cnt + 1;
        end else begin
            hi_cnt <= 0;
        end
    end

    // Purpose: count cycles since the last falling serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            gap_cnt <= 0;
        end else begin
            sck_d <= adc_sck;
            if (sck_d && !adc_sck) begin
                gap_cnt <= 1;
            end else if (gap_cnt != 32'hFFFF_FFFF) begin
                gap_cnt <= gap_cnt + 1;
            end
        end
    end

    assert_conv_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs) |-> (hi_cnt == CONV_CYCLES));

    assert_conv_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs |-> !adc_sck);

    assert_acq_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs) |-> (gap_cnt >= ACQ_CYCLES));

    assert_busy_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_cs || adc_sck) |-> !req_ready);

    assert_result_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_refuse_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ready && !adc_cs && !adc_sck));

endmodule

bind adcmux_ctrl adcmux_ctrl_chk #(
    .ACQ_CYCLES  (ACQ_CYCLES),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_err   (req_err),
    .res_valid (res_valid),
    .adc_cs    (adc_cs),
    .adc_sck   (adc_sck)
);

// File: tb/adcmux_ctrl_bench.sv
// Bench: behavioural converter model, own word encoder and timing reference.
module adcmux_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RES        = 16;
    localparam int CLK_MHZ    = 100;
    localparam int ACQ_NS     = 2010;
    localparam int CONV       = 350;
    localparam int ACQ        = (ACQ_NS * CLK_MHZ + 999) / 1000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [2:0]     req_chan = '0;
    logic           req_single = 1'b0;
    logic           req_swap = 1'b0;
    logic           req_com = 1'b0;
    logic           req_unipolar = 1'b0;
    logic           req_sleep = 1'b0;
    logic           req_err;
    logic           res_valid;
    logic [RES-1:0] res_data;
    logic [6:0]     res_tag;
    logic           res_first;
    logic           adc_cs;
    logic           adc_sck;
    logic           adc_sdi;
    logic           adc_sdo;

    int checks = 0;
    int errors = 0;
    int n_legal = 0;
    int n_results = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adcmux_ctrl #(
        .RES_BITS (RES), .CLK_MHZ (CLK_MHZ), .ACQ_NS (ACQ_NS),
        .CONV_CYCLES (CONV), .SCK_HALF (2)
    ) u_adcmux_ctrl (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_chan (req_chan), .req_single (req_single), .req_swap (req_swap),
        .req_com (req_com), .req_unipolar (req_unipolar), .req_sleep (req_sleep),
        .req_err (req_err), .res_valid (res_valid), .res_data (res_data),
        .res_tag (res_tag), .res_first (res_first), .adc_cs (adc_cs),
        .adc_sck (adc_sck), .adc_sdi (adc_sdi), .adc_sdo (adc_sdo)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] enc(logic [2:0] ch, logic sg, logic sw,
                                       logic cm, logic un, logic sl);
        int v;
        v = (sg ? 64 : 0) + ((sg ? ch[0] : sw) ? 32 : 0) + (ch[2] ? 16 : 0)
          + (ch[1] ? 8 : 0) + (cm ? 4 : 0) + (un ? 2 : 0) + (sl ? 1 : 0);
        return 7'(v);
    endfunction

    function automatic logic [RES-1:0] conv_val(int n, logic [6:0] cfg);
        return RES'((n + 1) * 40503) ^ {cfg, 9'd0};
    endfunction

    // Behavioural converter and expectation queues
    logic [6:0]     word_q[$];
    logic [RES-1:0] exp_data[$];
    logic [6:0]     exp_tag[$];
    bit             exp_first[$];
    logic [6:0]     adc_shift = '0;
    logic [6:0]     adc_cfg = '0;
    logic [RES-1:0] adc_out = '0;
    int             rx_n = 0;
    int             conv_n = 0;

    assign adc_sdo = adc_out[RES-1];

    always @(posedge adc_sck) begin
        if (rx_n < 7) adc_shift = {adc_shift[5:0], adc_sdi};
        else chk(adc_sdi == 1'b0, "R6", "pad bit on sdi", adc_sdi, 0);
        rx_n++;
    end

    always @(negedge adc_sck) adc_out = adc_out << 1;

    always @(posedge adc_cs) begin
        logic [6:0] w;
        chk(rx_n == RES, "R6", "serial clocks per phase", rx_n, RES);
        w = (word_q.size() > 0) ? word_q.pop_front() : 7'h7f;
        chk(adc_shift == w, "R2,R3,R4", "word received by converter", adc_shift, w);
        adc_cfg = adc_shift;
        rx_n = 0;
    end

    always @(negedge adc_cs) begin
        adc_out = conv_val(conv_n, adc_cfg);
        exp_data.push_back(adc_out);
        exp_tag.push_back(adc_cfg);
        exp_first.push_back(1'b0);
        conv_n++;
    end

    // Per-clock reference comparison away from the active edge
    int  gap = 0;
    int  hi = 0;
    bit  prev_sck = 0;
    bit  prev_cs = 0;
    bit  prev_valid = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (res_valid) begin
                n_results++;
                chk(!prev_valid, "R7", "result pulse width", 1, 0);
                if (exp_data.size() > 0) begin
                    logic [RES-1:0] d;
                    logic [6:0] t;
                    bit f;
                    d = exp_data.pop_front();
                    t = exp_tag.pop_front();
                    f = exp_first.pop_front();
                    chk(res_data == d, "R7", "res_data", res_data, d);
                    chk(res_tag == t, "R7", "res_tag", res_tag, t);
                    chk(res_first == f, "R7", "res_first", res_first, f);
                end else begin
                    chk(0, "R7", "unexpected result", 1, 0);
                end
            end
            if (prev_sck && !adc_sck) gap = 0;
            else gap++;
            if (adc_cs && !prev_cs) chk(gap == ACQ, "R8", "acquire cycles", gap, ACQ);
            if (adc_cs) hi++;
            if (!adc_cs && prev_cs) chk(hi == CONV, "R9", "convert high cycles", hi, CONV);
            if (!adc_cs) hi = 0;
            if (adc_cs) chk(!adc_sck, "R9", "sck during conversion", adc_sck, 0);
            if (adc_cs || adc_sck) chk(!req_ready, "R10", "ready while busy", req_ready, 0);
            prev_sck = adc_sck;
            prev_cs = adc_cs;
            prev_valid = res_valid;
        end
    end

    task automatic send(input logic [2:0] ch, input logic sg, input logic sw,
                        input logic cm, input logic un, input logic sl);
        bit bad;
        bad = cm && (ch[2:1] == 2'b11) && (sg ? ch[0] : 1'b1);
        while (!req_ready) @(negedge clk);
        req_chan = ch; req_single = sg; req_swap = sw;
        req_com = cm; req_unipolar = un; req_sleep = sl;
        req_valid = 1'b1;
        if (!bad) begin
            word_q.push_back(enc(ch, sg, sw, cm, un, sl));
            n_legal++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_err == bad, "R5", "req_err after accept", req_err, bad);
        if (bad) begin
            repeat (40) begin
                @(negedge clk);
                chk(!adc_cs && !adc_sck && req_ready && !req_err, "R5",
                    "quiet after refusal", {adc_cs, adc_sck, req_ready, req_err}, 4'b0010);
            end
        end else begin
            chk(!req_ready, "R10", "ready after accept", req_ready, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_data.push_back('0);
        exp_tag.push_back('0);
        exp_first.push_back(1'b1);
        repeat (4) @(negedge clk);
        chk(req_ready && !adc_cs && !adc_sck && !res_valid && !req_err, "R1",
            "state in reset", {req_ready, adc_cs, adc_sck, res_valid, req_err}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !adc_cs && !adc_sck && !res_valid && !req_err, "R1",
            "state after reset", {req_ready, adc_cs, adc_sck, res_valid, req_err}, 5'b10000);
        // R2: single-ended channels, top input ordinary
        for (int c = 0; c < 8; c++) send(3'(c), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R3: differential pairs, both polarities, chan[0] toggled to show no effect
        send(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send(3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        send(3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        send(3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        send(3'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        // R4: shared-return mode with coding and sleep bits
        send(3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        send(3'd6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        // R5: refused combinations, then legal traffic resumes
        send(3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        send(3'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        send(3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        send(3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        while (!req_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(n_results == n_legal, "R7", "result count", n_results, n_legal);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule